// File: doc/BRIEF.md
# GPIO Event Detect Interrupt Controller

This block watches a set of already-synchronized general-purpose pins and records events on them. Each pin has four separate detect enables: one for a rising edge, one for a falling edge, one for a high level and one for a low level. Any enabled condition sets that pin's bit in a latched event status vector. Software clears a status bit by writing a one to it.

The status bits whose pins have at least one detect enable set are ORed into three interrupt lines. Each line covers a fixed range of pins, and the middle range spans the 32-bit word boundary. Two further enable registers for asynchronous edge detection are kept only as storage. They reset to zero and can be written and read, but they have no effect on detection.

Each register is 64 bits wide, split into two 32-bit words: the lower word holds pins 0 to 31 and the upper word holds the remaining pins. The word at base+4 is the upper word. The bus is a plain single-cycle register port. Writes take effect on the clock edge where the write enable is high. Read data is combinational from the address.

Top module: `gpio_event_irq`

## Requirements
- R1: After reset, every register word reads zero and all three interrupt lines are low.
- R2: With the rising enable bit set (word base 0x4C), a 0-to-1 change on that pin sets its status bit at the next clock edge; a 1-to-0 change does not.
- R3: With the falling enable bit set (word base 0x58), a 1-to-0 change on that pin sets its status bit at the next clock edge.
- R4: With both edge enables set on one pin, either direction of change sets its status bit.
- R5: With the high-level enable set (word base 0x64), the status bit is set on every cycle the pin is 1, so a clear written while the pin is still high leaves the bit set.
- R6: With the low-level enable set (word base 0x70), the status bit is set on every cycle the pin is 0, so a clear written while the pin is still low leaves the bit set.
- R7: Writing the status words (base 0x40) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: A status bit stays set after its enable is cleared until a one is written to it.
- R9: Interrupt line 0 covers pins 0 to 27, line 1 covers pins 28 to 45, and line 2 covers pins 46 to 57. A line goes high one clock after a status bit in its range is set, provided that pin is enabled.
- R10: A status bit whose pin has none of the four detect enables set does not drive any interrupt line.
- R11: The asynchronous rising (base 0x7C) and falling (base 0x88) enable words read back what was written, but they never set a status bit.
- R12: Bits of the upper word above the last pin (bits 26 to 31 for 58 pins) are not stored and read as zero. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register word |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| pinIn | input | 58 | Synchronized pin levels |
| irqOut | output | 3 | Range interrupt lines |

## Verification
Every pin is swept through all four detect modes. For each one the bench checks the status bit position, the interrupt line chosen for that pin, and the behaviour of a clear. This catches a range boundary off by one at 27/28 or 45/46, and a status word that drops or shifts the bits above 31. A level detector that lets a clear win over a persisting level would read back zero where R5 and R6 expect one. A clear that acts as a plain write would wipe the neighbouring bits that R7 keeps. Separate checks cover the remaining cases: status that survives a disabled enable but no longer raises an interrupt, asynchronous enable words that wrongly trigger detection, and padding bits that read back as ones.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  // Register selector; the first six index the enable array in this order.
  typedef enum logic [2:0] {
    RG_RISE   = 3'd0,
    RG_FALL   = 3'd1,
    RG_HIGH   = 3'd2,
    RG_LOW    = 3'd3,
    RG_ARISE  = 3'd4,
    RG_AFALL  = 3'd5,
    RG_STATUS = 3'd6,
    RG_NONE   = 3'd7
  } regSel_e;

  localparam int NUM_EN   = 6;
  localparam int NUM_SYNC = 4;

  typedef struct packed {
    logic    wrStrobe;
    logic    bankHi;
    regSel_e sel;
  } ctrlStrobe_t;

  function automatic logic [7:0] baseOf(regSel_e s);
    case (s)
      RG_STATUS: baseOf = 8'h40;
      RG_RISE:   baseOf = 8'h4C;
      RG_FALL:   baseOf = 8'h58;
      RG_HIGH:   baseOf = 8'h64;
      RG_LOW:    baseOf = 8'h70;
      RG_ARISE:  baseOf = 8'h7C;
      RG_AFALL:  baseOf = 8'h88;
      default:   baseOf = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strb
);

  always_comb begin
    strb.sel    = RG_NONE;
    strb.bankHi = 1'b0;
    for (int k = 0; k < 7; k++) begin
      if (busAddr == ADDR_W'(baseOf(regSel_e'(3'(k))))) begin
        strb.sel    = regSel_e'(3'(k));
        strb.bankHi = 1'b0;
      end else if (busAddr == ADDR_W'(baseOf(regSel_e'(3'(k))) + 8'd4)) begin
        strb.sel    = regSel_e'(3'(k));
        strb.bankHi = 1'b1;
      end
    end
    strb.wrStrobe = busWrEn && (strb.sel != RG_NONE);
  end

endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS  = 58,
  parameter int IRQ0_LAST = 27,
  parameter int IRQ1_LAST = 45
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strb,
  input  logic [31:0]         busWrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [31:0]         busRdData,
  output logic [2:0]          irqOut,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] enAny
);

  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;
  localparam logic [PAD_W-1:0] VALID_MASK = PAD_W'({NUM_PINS{1'b1}});

  logic [PAD_W-1:0] enReg [NUM_EN];
  logic [PAD_W-1:0] statusReg;
  logic [PAD_W-1:0] prevPin;
  logic [PAD_W-1:0] pinPad;
  logic [PAD_W-1:0] clrVec;
  logic [PAD_W-1:0] eventVec;
  logic [PAD_W-1:0] pending;
  logic [PAD_W-1:0] anyPad;
  logic [2:0]       irqNext;
  logic [2:0]       irqReg;
  int               wordBase;

  assign pinPad   = PAD_W'(pinIn);
  assign wordBase = int'(strb.bankHi) * 32;

  // Only the four synchronous enables take part in detection.
  assign anyPad = enReg[RG_RISE] | enReg[RG_FALL] | enReg[RG_HIGH] | enReg[RG_LOW];

  assign eventVec = VALID_MASK & (
      (enReg[RG_RISE] &  pinPad & ~prevPin) |
      (enReg[RG_FALL] & ~pinPad &  prevPin) |
      (enReg[RG_HIGH] &  pinPad) |
      (enReg[RG_LOW]  & ~pinPad));

  always_comb begin
    clrVec = '0;
    if (strb.wrStrobe && strb.sel == RG_STATUS)
      clrVec[wordBase +: 32] = busWrData;
    clrVec = clrVec & VALID_MASK;
  end

  assign pending = statusReg & anyPad;

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_irq
      localparam int LO = (g == 0) ? 0 : (g == 1) ? IRQ0_LAST + 1 : IRQ1_LAST + 1;
      localparam int HI = (g == 0) ? IRQ0_LAST : (g == 1) ? IRQ1_LAST : NUM_PINS - 1;
      assign irqNext[g] = |pending[HI:LO];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_EN; k++) enReg[k] <= '0;
      statusReg <= '0;
      prevPin   <= '0;
      irqReg    <= '0;
    end else begin
      for (int k = 0; k < NUM_EN; k++) begin
        if (strb.wrStrobe && strb.sel == regSel_e'(3'(k)))
          enReg[k][wordBase +: 32] <= busWrData & VALID_MASK[wordBase +: 32];
      end
      // A new event in the same cycle wins over a clear.
      statusReg <= (statusReg & ~clrVec) | eventVec;
      prevPin   <= pinPad;
      irqReg    <= irqNext;
    end
  end

  always_comb begin
    busRdData = '0;
    if (strb.sel == RG_STATUS) begin
      busRdData = statusReg[wordBase +: 32];
    end else begin
      for (int k = 0; k < NUM_EN; k++)
        if (strb.sel == regSel_e'(3'(k))) busRdData = enReg[k][wordBase +: 32];
    end
  end

  assign irqOut    = irqReg;
  assign statusVec = statusReg[NUM_PINS-1:0];
  assign enAny     = anyPad[NUM_PINS-1:0];

endmodule

// File: rtl/gpio_event_irq.sv
module gpio_event_irq
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS  = 58,
  parameter int ADDR_W    = 8,
  parameter int IRQ0_LAST = 27,
  parameter int IRQ1_LAST = 45
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [2:0]          irqOut
);

  ctrlStrobe_t         strb;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] enAny;

  gpio_evt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  gpio_evt_dp #(
    .NUM_PINS  (NUM_PINS),
    .IRQ0_LAST (IRQ0_LAST),
    .IRQ1_LAST (IRQ1_LAST)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .busWrData (busWrData),
    .pinIn     (pinIn),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .statusVec (statusVec),
    .enAny     (enAny)
  );

endmodule

// File: rtl/gpio_event_irq_chk.sv
module gpio_event_irq_chk #(
  parameter int NUM_PINS  = 58,
  parameter int ADDR_W    = 8,
  parameter int IRQ0_LAST = 27
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [31:0]         busRdData,
  input logic [2:0]          irqOut,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] enAny
);

  logic stWr;
  assign stWr = busWrEn && (busAddr == ADDR_W'(8'h40) || busAddr == ADDR_W'(8'h44));

  // R2
  new_bit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusVec & ~$past(statusVec)) & ~$past(enAny)) == '0);

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stWr) |-> (($past(statusVec) & ~statusVec) == '0));

  // R9
  irq0_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut[0] |-> $past(|(statusVec[IRQ0_LAST:0] & enAny[IRQ0_LAST:0])));

  // R10
  irq_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enAny) == '0) |-> (irqOut == 3'b000));

  generate
    if (NUM_PINS < 64) begin : g_pad
      // R12
      pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busAddr == ADDR_W'(8'h44)) |-> (busRdData[31:NUM_PINS-32] == '0));
    end
  endgenerate

endmodule

bind gpio_event_irq gpio_event_irq_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .IRQ0_LAST (IRQ0_LAST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .enAny     (enAny)
);

// File: tb/gpio_event_irq_bench.sv
module gpio_event_irq_bench;
  localparam int NP = 58;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [NP-1:0] pins = '0;
  logic [2:0]    irqOut;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  gpio_event_irq u_gpio_event_irq (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pins), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic rdStatus(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(8'h40, lo);
    rd(8'h44, hi);
    s = {hi, lo};
  endtask

  task automatic clearAll();
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
  endtask

  function automatic logic [2:0] irqFor(input int p);
    if (p < 28) return 3'b001;
    if (p < 46) return 3'b010;
    return 3'b100;
  endfunction

  initial begin
    logic [63:0] s;
    logic [31:0] d;
    logic [7:0]  bases[7] = '{8'h40, 8'h4C, 8'h58, 8'h64, 8'h70, 8'h7C, 8'h88};
    logic [7:0]  modeBase[4] = '{8'h4C, 8'h58, 8'h64, 8'h70};
    string       modeTag[4] = '{"R2", "R3", "R5", "R6"};

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state of all register words and lines
    for (int r = 0; r < 7; r++) begin
      rd(bases[r], d);       check("R1", 64'(d), 64'h0);
      rd(bases[r] + 8'd4, d); check("R1", 64'(d), 64'h0);
    end
    check("R1 irq", 64'(irqOut), 64'h0);

    // Sweep every pin through every mode
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic inact;
        logic [7:0] ea;
        logic [63:0] bitP;
        inact = (m == 1 || m == 3);
        ea = modeBase[m] + ((p >= 32) ? 8'd4 : 8'd0);
        bitP = 64'h1 << p;
        pins = '0; pins[p] = inact;
        idle(2);
        wr(ea, 32'h1 << (p % 32));
        clearAll();
        idle(1);
        rdStatus(s); check(modeTag[m], s, 64'h0);
        check("R9 idle", 64'(irqOut), 64'h0);
        @(negedge clk) pins[p] = ~inact;
        @(negedge clk);
        rdStatus(s); check(modeTag[m], s, bitP);
        @(negedge clk);
        check("R9", 64'(irqOut), 64'(irqFor(p)));
        wr(8'h40 + ((p >= 32) ? 8'd4 : 8'd0), 32'h1 << (p % 32));
        rdStatus(s);
        check((m >= 2) ? modeTag[m] : "R7", s, (m >= 2) ? bitP : 64'h0);
        wr(ea, 32'h0);
        pins[p] = inact;
        clearAll();
        idle(1);
        rdStatus(s); check("R7", s, 64'h0);
      end
    end

    // R2: falling change ignored with rising-only enable
    pins = '0; pins[7] = 1'b1; idle(2);
    wr(8'h4C, 32'h80); clearAll();
    @(negedge clk) pins[7] = 1'b0;
    idle(2);
    rdStatus(s); check("R2 fall ignored", s, 64'h0);
    wr(8'h4C, 32'h0);

    // R4: both edges on pin 5
    pins = '0; idle(2);
    wr(8'h4C, 32'h20); wr(8'h58, 32'h20); clearAll();
    @(negedge clk) pins[5] = 1'b1;
    @(negedge clk); rdStatus(s); check("R4 rise", s, 64'h20);
    clearAll();
    rdStatus(s); check("R4 cleared", s, 64'h0);
    @(negedge clk) pins[5] = 1'b0;
    @(negedge clk); rdStatus(s); check("R4 fall", s, 64'h20);
    wr(8'h4C, 32'h0); wr(8'h58, 32'h0); clearAll();

    // R7: zeros in a clear leave other bits alone
    pins = '0; idle(2);
    wr(8'h4C, 32'h8); wr(8'h50, 32'h100); clearAll();
    @(negedge clk) begin pins[3] = 1'b1; pins[40] = 1'b1; end
    @(negedge clk);
    rdStatus(s); check("R7 both set", s, (64'h1 << 40) | 64'h8);
    wr(8'h40, 32'h8);
    rdStatus(s); check("R7 partial", s, 64'h1 << 40);
    wr(8'h44, 32'h0);
    rdStatus(s); check("R7 zero write", s, 64'h1 << 40);

    // R8 and R10: status survives disable, interrupt drops
    wr(8'h4C, 32'h0); wr(8'h50, 32'h0);
    idle(2);
    rdStatus(s); check("R8 latched", s, 64'h1 << 40);
    check("R10 irq masked", 64'(irqOut), 64'h0);
    clearAll();
    rdStatus(s); check("R8 cleared", s, 64'h0);

    // R11: async enable storage only
    pins = '0; idle(2);
    wr(8'h7C, 32'hFFFF_FFFF); wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h88, 32'h1234_5678); wr(8'h8C, 32'h0000_00FF);
    rd(8'h7C, d); check("R11 readback", 64'(d), 64'hFFFF_FFFF);
    rd(8'h88, d); check("R11 readback", 64'(d), 64'h1234_5678);
    rd(8'h8C, d); check("R11 readback", 64'(d), 64'hFF);
    @(negedge clk) pins = '1;
    @(negedge clk) pins = '0;
    idle(2);
    rdStatus(s); check("R11 no effect", s, 64'h0);
    check("R11 irq", 64'(irqOut), 64'h0);

    // R12: padding bits and unmapped address
    rd(8'h80, d); check("R12 pad", 64'(d), 64'h03FF_FFFF);
    wr(8'h68, 32'hFFFF_FFFF);
    rd(8'h68, d); check("R12 pad", 64'(d), 64'h03FF_FFFF);
    wr(8'h68, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R12 unmapped", 64'(d), 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule